// File: doc/BRIEF.md
# GCI Frame Multiplexer

This block assembles the upstream serial frame and takes apart the downstream serial frame of a four-channel voice codec on a GCI-style line-card bus. Every 125 µs frame is marked by an 8 kHz frame sync. It holds eight slots of four bytes each and runs at 2.048 Mbit/s. The data clock may be 2.048 MHz or 4.096 MHz. The block measures the clock cycles between frame syncs to tell the two rates apart. At the faster rate each bit lasts two clock cycles.

Upstream, the block takes per-channel voice bytes or 14-bit linear samples, two monitor bytes and two C/I sets. It loads them into holding registers at frame sync and shifts them out MSB first into the slots that the strap and the coding mode select. Every other bit time is driven high. Downstream, it rebuilds each byte that belongs to an assigned position. It presents the byte for one cycle with the slot and byte index beside it. Unassigned positions give no strobe.

Compressed coding uses two adjacent slots chosen by the strap. Each slot carries voice A, voice B, monitor and C/I, in that order. Linear coding needs the strap at 00. Slots 0 and 1 then carry the control bytes and slots 4 and 5 carry the 16-bit samples.

Top module: `gci_frame_mux`

## Requirements
- R1: During reset and after it, until the first frame sync, du is 1, rx_valid is 0 and rate_hi is 0.
- R2: With lin_mode=0 the frame sync edge starts bit 0 in the next cycle, and bits go out MSB first. A slot is 32 bits and a byte is 8 bits. In the first assigned slot, byte 0 is channel 0 voice (tx_voice[7:0]) and byte 1 is channel 1 voice. In the second slot, bytes 0 and 1 are channels 2 and 3 (tx_voice[31:16]). Byte 2 is the monitor byte of that pair (tx_mon[7:0] for the first slot, [15:8] for the second).
- R3: Byte 3 of a control slot holds the 6-bit C/I field in bits 7..2, the active-low MR in bit 1 and the active-low MX in bit 0. Pair 0 uses tx_ci[5:0] and pair 1 uses tx_ci[11:6]. The levels are sent as given.
- R4: With lin_mode=0 the assigned slots are 2*slot_sel and 2*slot_sel+1. Every byte of every other slot is 8'hFF.
- R5: With lin_mode=1 and slot_sel=00, slots 0 and 1 send 8'hFF in bytes 0 and 1, and the monitor and C/I bytes in bytes 2 and 3. Slot 4 carries channels 0 and 1 and slot 5 carries channels 2 and 3, each as a 16-bit word, high byte first. The word is the 14-bit tx_lin field sign-extended into bits 15 and 14. Slots 2, 3, 6 and 7 are 8'hFF.
- R6: With lin_mode=1 and slot_sel other than 00, du stays 1 for the whole frame and no downstream strobe is given.
- R7: For each assigned position (the same positions that R2, R4 and R5 fill upstream, but only bytes 2 and 3 of linear control slots), the dd byte received MSB first appears on rx_data. It comes with a one-cycle rx_valid and rx_slot/rx_idx tags, in the cycle after the byte's last bit is sampled. No other position gives a strobe.
- R8: A frame-sync period of 256 clocks sets rate_hi=0 and one of 512 clocks sets rate_hi=1. Any other period leaves rate_hi unchanged. With rate_hi=1 each bit is held for two clocks and dd is sampled on the second.
- R9: The holding registers, lin_mode and slot_sel are taken only at the frame sync edge. Changes during a frame do not alter that frame.
- R10: If no frame sync arrives after a full frame, du stays 1 and no strobe is given until the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock, 2.048 or 4.096 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync, high for one clock before bit 0 |
| slot_sel | input | 2 | Slot assignment strap |
| lin_mode | input | 1 | 0 compressed, 1 linear coding |
| tx_voice | input | 32 | Compressed voice bytes, channel n at [8n+7:8n] |
| tx_lin | input | 56 | Linear samples, channel n at [14n+13:14n] |
| tx_mon | input | 16 | Monitor bytes, pair 0 low |
| tx_ci | input | 12 | C/I fields, pair 0 low |
| tx_mx_n | input | 2 | Active-low monitor transmit flags per pair |
| tx_mr_n | input | 2 | Active-low monitor receive flags per pair |
| dd | input | 1 | Downstream serial data |
| du | output | 1 | Upstream serial data |
| rate_hi | output | 1 | 1 when the 4.096 MHz clock is detected |
| rx_valid | output | 1 | Downstream byte strobe |
| rx_slot | output | 3 | Slot of the strobed byte |
| rx_idx | output | 2 | Byte index within the slot |
| rx_data | output | 8 | Received byte |

## Verification
The block has no parameters, so the bench builds it in its single fixed shape. That shape is enough to reach both clock rates and every coding mode. The bench switches the frame-sync period between 256 and 512 clocks and inserts an overlong period. This exercises rate detection in both directions, the hold on an odd period and the idle fill after a missing sync. Frames are run under three strap values in compressed mode, under a valid and an invalid strap in linear mode, and with inputs changed in the middle of a frame.

// File: rtl/gci_frame_mux.sv
module gci_frame_mux (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fsync,
  input  logic [1:0]  slot_sel,
  input  logic        lin_mode,
  input  logic [31:0] tx_voice,
  input  logic [55:0] tx_lin,
  input  logic [15:0] tx_mon,
  input  logic [11:0] tx_ci,
  input  logic [1:0]  tx_mx_n,
  input  logic [1:0]  tx_mr_n,
  input  logic        dd,
  output logic        du,
  output logic        rate_hi,
  output logic        rx_valid,
  output logic [2:0]  rx_slot,
  output logic [1:0]  rx_idx,
  output logic [7:0]  rx_data
);
  logic [9:0]  fcnt;
  logic [31:0] sh_voice;
  logic [55:0] sh_lin;
  logic [15:0] sh_mon, sh_cib;
  logic        sh_lin_m;
  logic [1:0]  sh_sel;
  logic [6:0]  sr;
  logic [7:0]  bitn, up, vbyte, mbyte, cbyte;
  logic [2:0]  slot, bpos;
  logic [1:0]  bidx;
  logic        in_rng, smp, take;
  logic [13:0] lraw;
  logic [15:0] lword;

  assign in_rng = rate_hi ? ~fcnt[9] : (fcnt[9:8] == 2'b00);
  assign bitn   = rate_hi ? fcnt[8:1] : fcnt[7:0];
  assign slot   = bitn[7:5];
  assign bidx   = bitn[4:3];
  assign bpos   = bitn[2:0];
  assign smp    = in_rng & (~rate_hi | fcnt[0]);

  assign mbyte = slot[0] ? sh_mon[15:8] : sh_mon[7:0];
  assign cbyte = slot[0] ? sh_cib[15:8] : sh_cib[7:0];

  always_comb begin
    case ({slot[0], bidx[0]})
      2'd0:    vbyte = sh_voice[7:0];
      2'd1:    vbyte = sh_voice[15:8];
      2'd2:    vbyte = sh_voice[23:16];
      default: vbyte = sh_voice[31:24];
    endcase
  end

  always_comb begin
    case ({slot[0], bidx[1]})
      2'd0:    lraw = sh_lin[13:0];
      2'd1:    lraw = sh_lin[27:14];
      2'd2:    lraw = sh_lin[41:28];
      default: lraw = sh_lin[55:42];
    endcase
  end

  assign lword = {{2{lraw[13]}}, lraw};

  always_comb begin
    up   = 8'hFF;
    take = 1'b0;
    if (!sh_lin_m) begin
      if (slot[2:1] == sh_sel) begin
        take = 1'b1;
        case (bidx)
          2'd2:    up = mbyte;
          2'd3:    up = cbyte;
          default: up = vbyte;
        endcase
      end
    end else if (sh_sel == 2'b00) begin
      if (slot[2:1] == 2'b00) begin
        take = bidx[1];
        if (bidx == 2'd2)      up = mbyte;
        else if (bidx == 2'd3) up = cbyte;
      end else if (slot[2:1] == 2'b10) begin
        take = 1'b1;
        up   = bidx[0] ? lword[7:0] : lword[15:8];
      end
    end
  end

  assign du = in_rng ? up[~bpos] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt     <= '1;
      rate_hi  <= 1'b0;
      sh_voice <= '0;
      sh_lin   <= '0;
      sh_mon   <= '0;
      sh_cib   <= '0;
      sh_lin_m <= 1'b0;
      sh_sel   <= 2'b00;
    end else if (fsync) begin
      fcnt <= '0;
      if (fcnt == 10'd255)      rate_hi <= 1'b0;
      else if (fcnt == 10'd511) rate_hi <= 1'b1;
      sh_voice <= tx_voice;
      sh_lin   <= tx_lin;
      sh_mon   <= tx_mon;
      sh_cib   <= {tx_ci[11:6], tx_mr_n[1], tx_mx_n[1], tx_ci[5:0], tx_mr_n[0], tx_mx_n[0]};
      sh_lin_m <= lin_mode;
      sh_sel   <= slot_sel;
    end else if (fcnt != 10'h3FF) begin
      fcnt <= fcnt + 10'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      rx_valid <= 1'b0;
      rx_slot  <= '0;
      rx_idx   <= '0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (smp) begin
        sr <= {sr[5:0], dd};
        if (bpos == 3'd7 && take) begin
          rx_valid <= 1'b1;
          rx_data  <= {sr, dd};
          rx_slot  <= slot;
          rx_idx   <= bidx;
        end
      end
    end
  end
endmodule

// File: rtl/gci_frame_mux_chk.sv
module gci_frame_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fsync,
  input logic       du,
  input logic       rate_hi,
  input logic       rx_valid,
  input logic [2:0] rx_slot,
  input logic [1:0] rx_idx,
  input logic [9:0] fcnt,
  input logic       sh_lin_m,
  input logic [1:0] sh_sel
);
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_bad_strap_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_lin_m && sh_sel != 2'b00) |-> du);

  a_r6_bad_strap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_lin_m && sh_sel != 2'b00 && $past(sh_lin_m && sh_sel != 2'b00)) |-> !rx_valid);

  a_r4_strobe_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !sh_lin_m && !$past(fsync)) |-> (rx_slot[2:1] == sh_sel));

  a_r5_strobe_lin: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && sh_lin_m && !$past(fsync)) |->
      ((rx_slot == 3'd4) || (rx_slot == 3'd5) || (rx_slot[2:1] == 2'b00 && rx_idx[1])));

  a_r8_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fsync) |-> $stable(rate_hi));

  a_r10_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt == 10'h3FF) |-> du);
endmodule

bind gci_frame_mux gci_frame_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .du(du), .rate_hi(rate_hi),
  .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_idx(rx_idx), .fcnt(fcnt),
  .sh_lin_m(sh_lin_m), .sh_sel(sh_sel)
);

// File: tb/gci_frame_mux_tb.sv
module gci_frame_mux_tb;
  logic clk = 1'b0;
  logic rst_n, fsync, lin_mode, dd;
  logic [1:0] slot_sel, tx_mx_n, tx_mr_n;
  logic [31:0] tx_voice;
  logic [55:0] tx_lin;
  logic [15:0] tx_mon;
  logic [11:0] tx_ci;
  logic du, rate_hi, rx_valid;
  logic [2:0] rx_slot;
  logic [1:0] rx_idx;
  logic [7:0] rx_data;

  int nchk = 0, nerr = 0, seed = 0;

  logic [31:0] s_voice;
  logic [55:0] s_lin_v;
  logic [15:0] s_mon;
  logic [11:0] s_ci;
  logic [1:0]  s_mx, s_mr, s_sel;
  logic        s_lin;

  logic        pend = 1'b0, p_lin;
  logic [1:0]  p_sel;
  int          p_seed;
  logic        got_v [32];
  logic [7:0]  got_d [32];

  always #2 clk = ~clk;

  gci_frame_mux u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .slot_sel(slot_sel), .lin_mode(lin_mode),
    .tx_voice(tx_voice), .tx_lin(tx_lin), .tx_mon(tx_mon), .tx_ci(tx_ci),
    .tx_mx_n(tx_mx_n), .tx_mr_n(tx_mr_n), .dd(dd), .du(du), .rate_hi(rate_hi),
    .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_idx(rx_idx), .rx_data(rx_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_up(input int s, input int b);
    int p = s % 2;
    int ch;
    logic [7:0] cb = p ? {s_ci[11:6], s_mr[1], s_mx[1]} : {s_ci[5:0], s_mr[0], s_mx[0]};
    logic [7:0] mb = p ? s_mon[15:8] : s_mon[7:0];
    logic [15:0] lw;
    if (!s_lin) begin
      if (s / 2 != int'(s_sel)) return 8'hFF;
      if (b == 2) return mb;
      if (b == 3) return cb;
      ch = 2 * p + b;
      return s_voice[ch*8 +: 8];
    end
    if (s_sel != 2'b00) return 8'hFF;
    if (s < 2) return (b == 2) ? mb : (b == 3) ? cb : 8'hFF;
    if (s == 4 || s == 5) begin
      ch = 2 * p + b / 2;
      lw = {{2{s_lin_v[ch*14+13]}}, s_lin_v[ch*14 +: 14]};
      return (b % 2 == 0) ? lw[15:8] : lw[7:0];
    end
    return 8'hFF;
  endfunction

  function automatic logic rx_exp(input int s, input int b, input logic lin, input logic [1:0] sel);
    if (!lin) return (s / 2 == int'(sel));
    return (sel == 2'b00) && ((s < 2 && b >= 2) || s == 4 || s == 5);
  endfunction

  function automatic logic [7:0] ddpat(input int s, input int b, input int sd);
    return 8'((s * 37 + b * 91 + sd * 13) ^ 8'h5A);
  endfunction

  task automatic grab();
    if (rx_valid) begin
      got_v[{rx_slot, rx_idx}] = 1'b1;
      got_d[{rx_slot, rx_idx}] = rx_data;
    end
  endtask

  task automatic settle();
    if (pend) begin
      for (int i = 0; i < 32; i++) begin
        chk("R7", $sformatf("strobe slot %0d byte %0d", i / 4, i % 4),
            int'(got_v[i]), int'(rx_exp(i / 4, i % 4, p_lin, p_sel)));
        if (got_v[i] && rx_exp(i / 4, i % 4, p_lin, p_sel))
          chk("R7", $sformatf("rx byte slot %0d byte %0d", i / 4, i % 4),
              int'(got_d[i]), int'(ddpat(i / 4, i % 4, p_seed)));
      end
    end
    for (int i = 0; i < 32; i++) got_v[i] = 1'b0;
  endtask

  task automatic run_frame(input bit hi, input bit chkit, input int extra, input string req, input bit mid);
    int len = hi ? 512 : 256;
    logic [7:0] upb [32];
    logic h0 = 1'b0;
    bit halfbad = 0, idlebad = 0;
    fsync = 1'b1;
    s_voice = tx_voice; s_lin_v = tx_lin; s_mon = tx_mon; s_ci = tx_ci;
    s_mx = tx_mx_n; s_mr = tx_mr_n; s_sel = slot_sel; s_lin = lin_mode;
    for (int c = 0; c < len; c++) begin
      int bn = hi ? c / 2 : c;
      int s = bn / 32, b = (bn / 8) % 4, k = 7 - bn % 8;
      @(negedge clk);
      grab();
      if (c == 0) begin
        fsync = 1'b0;
        settle();
        pend = chkit; p_lin = s_lin; p_sel = s_sel; p_seed = seed;
      end
      if (mid && c == len / 2) begin
        tx_voice = ~tx_voice; tx_mon = ~tx_mon; tx_ci = ~tx_ci; tx_lin = ~tx_lin;
        tx_mx_n = ~tx_mx_n; tx_mr_n = ~tx_mr_n; slot_sel = ~slot_sel; lin_mode = ~lin_mode;
      end
      dd = ddpat(s, b, seed)[k];
      if (!hi || (c % 2 == 1)) begin
        upb[s*4+b][k] = du;
        if (hi && du != h0) halfbad = 1;
      end else begin
        h0 = du;
      end
    end
    if (chkit) begin
      for (int i = 0; i < 32; i++)
        chk(req, $sformatf("du slot %0d byte %0d", i / 4, i % 4), int'(upb[i]), int'(exp_up(i / 4, i % 4)));
      if (hi) chk("R8", "bit held over both clocks", int'(halfbad), 0);
    end
    for (int e = 0; e < extra; e++) begin
      @(negedge clk);
      grab();
      if (e == 0) begin
        settle();
        pend = 1'b0;
      end else if (du != 1'b1 || rx_valid) begin
        idlebad = 1;
      end
    end
    if (extra > 1) chk("R10", "idle after missing sync", int'(idlebad), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fsync = 1'b0; dd = 1'b1; lin_mode = 1'b0; slot_sel = 2'b00;
    tx_voice = '0; tx_lin = '0; tx_mon = '0; tx_ci = '0; tx_mx_n = 2'b11; tx_mr_n = 2'b11;
    for (int i = 0; i < 32; i++) begin got_v[i] = 1'b0; got_d[i] = '0; end
    repeat (4) @(negedge clk);
    chk("R1", "du in reset", int'(du), 1);
    chk("R1", "rx_valid in reset", int'(rx_valid), 0);
    chk("R1", "rate_hi in reset", int'(rate_hi), 0);
    rst_n = 1'b1;
    begin
      bit bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (du != 1'b1 || rx_valid || rate_hi) bad = 1;
      end
      chk("R1", "idle before first sync", int'(bad), 0);
    end
  endtask

  task automatic t_compressed();
    tx_voice = 32'hC3A5_1E96; tx_mon = 16'h7E81; tx_ci = 12'b101100_010011;
    tx_mx_n = 2'b10; tx_mr_n = 2'b01; seed = 1;
    run_frame(0, 0, 0, "", 0);
    slot_sel = 2'b00; seed = 2;
    run_frame(0, 1, 0, "R2", 0);
    slot_sel = 2'b10; tx_voice = 32'h0F1E_2D3C; tx_mon = 16'h5AA5; seed = 3;
    run_frame(0, 1, 0, "R4", 0);
    slot_sel = 2'b11; tx_ci = 12'b011010_100101; tx_mx_n = 2'b01; tx_mr_n = 2'b10; seed = 4;
    run_frame(0, 1, 0, "R3", 0);
    chk("R8", "rate low at 256", int'(rate_hi), 0);
  endtask

  task automatic t_linear();
    lin_mode = 1'b1; slot_sel = 2'b00;
    tx_lin = {14'h2001, 14'h1FFF, 14'h3ABC, 14'h0123}; tx_mon = 16'h3CC3; seed = 5;
    run_frame(0, 1, 0, "R5", 0);
    slot_sel = 2'b01; seed = 6;
    run_frame(0, 1, 0, "R6", 0);
  endtask

  task automatic t_freeze();
    lin_mode = 1'b0; slot_sel = 2'b01; tx_voice = 32'h8142_2418; seed = 7;
    run_frame(0, 1, 0, "R9", 1);
    lin_mode = 1'b0; slot_sel = 2'b01;
  endtask

  task automatic t_fast();
    seed = 8;
    run_frame(1, 0, 0, "", 0);
    slot_sel = 2'b01; tx_voice = 32'h6699_AA55; seed = 9;
    run_frame(1, 1, 0, "R8", 0);
    chk("R8", "rate high at 512", int'(rate_hi), 1);
    lin_mode = 1'b1; slot_sel = 2'b00; tx_lin = {14'h0F0F, 14'h2222, 14'h1111, 14'h3FFF}; seed = 10;
    run_frame(1, 1, 0, "R8", 0);
  endtask

  task automatic t_nosync();
    lin_mode = 1'b0; slot_sel = 2'b00; seed = 11;
    run_frame(1, 1, 40, "R10", 0);
    seed = 12;
    run_frame(1, 1, 0, "R8", 0);
    chk("R8", "rate kept after odd period", int'(rate_hi), 1);
  endtask

  task automatic t_back_low();
    seed = 13;
    run_frame(0, 0, 0, "", 0);
    slot_sel = 2'b10; seed = 14;
    run_frame(0, 1, 10, "R8", 0);
    chk("R8", "rate back low", int'(rate_hi), 0);
  endtask

  initial begin
    t_reset();
    t_compressed();
    t_linear();
    t_freeze();
    t_fast();
    t_nosync();
    t_back_low();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule